// File: doc/BRIEF.md
# Serial Error-Trapping Decoder for the (15,11) Cyclic Code

This block repairs 15-bit words of the single-error-correcting cyclic code built on the generator g(x) = 1 + x + x^4. Eleven message bits and four check bits make up each word. The received word enters one bit per clock, highest-order coefficient first. As it arrives it is copied into a 15-bit word buffer and divided by g(x) in a 4-stage syndrome register. Once the last bit is in, the block waits until the operator gives a go signal (`sr`).

After the go signal, the buffer and the syndrome register turn together through exactly one full revolution of 15 clocks. At each step a fixed comparator checks the syndrome against the value that an error in the x^14 position would leave, which is x^3+1. On a match, the bit leaving the top of the buffer is inverted, and the same correction is folded back into the syndrome. After the revolution the buffer again holds the word in its original order, now repaired, and it is shifted out serially in the same order it arrived in.

The block corrects at most one bit error per word. No syndrome-to-position table is used: the rotation brings every position to the single fixed detector in turn.

Top module: `bch_meggitt_dec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `d_valid` and `d_out` are both 0.
- R2: In the idle phase, a rising edge that samples `start`=1 and `sr`=0 captures `d_in` as the x^14 coefficient. The next 14 edges capture x^13 down to x^0, one per edge, whatever `start` and `sr` are doing.
- R3: In the idle phase, an edge that samples `start`=1 together with `sr`=1 starts nothing. The block stays idle, `d_valid` stays 0, and a later legal start is accepted as usual.
- R4: After loading, the block holds the word for any number of cycles until an edge samples `sr`=1; call that edge E. `d_valid` is 1 from edge E+15 until edge E+30, which is exactly 15 cycles. During that window `d_out` carries the word with the x^14 coefficient first.
- R5: A received word that is a codeword (divisible by g(x)) comes out bit-for-bit unchanged. `d_out` is 0 whenever `d_valid` is 0.
- R6: A codeword with exactly one bit inverted, at any of the 15 positions, comes out as the original codeword. The correction fires when the syndrome equals x^3+1 (binary 1001, x^3 as the MSB), at most once per word, and the syndrome is zero at the end of the revolution. For example, 111110001100111 (x^14 first) comes out as 110110001100111.
- R7: `d_in`, `start` and `sr` have no effect while the block is waiting, rotating or sending, apart from `sr` ending the wait. The block returns to idle at edge E+30 and accepts a start sampled at edge E+31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins loading when sampled high in idle with `sr` low |
| sr | input | 1 | Go signal: ends the wait after loading and starts the correction pass |
| d_in | input | 1 | Received word, one bit per clock, highest-order first |
| d_out | output | 1 | Corrected word, one bit per clock, highest-order first; 0 outside the output window |
| d_valid | output | 1 | High during the 15 cycles in which `d_out` carries the corrected word |

## Verification
The hardest case to reach is an error in the low check-bit positions, because it is trapped only late in the revolution, after the syndrome has been multiplied by x many times. The stimulus therefore places a single inverted bit at every one of the 15 positions, in several random codewords each, and compares every output bit against the original codeword. Junk on `d_in`, `start` and `sr` is driven throughout the waiting, rotation and output phases, and idle cycles with `start` and `sr` both high are followed by a legal frame, so that any early or false start would show up as a misplaced or missing output window.

// File: rtl/bch_dec_pkg.sv
package bch_dec_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_HOLD,
      PH_ROT,
      PH_SEND
   } phase_e;

   // Remainder of x^(n-1) divided by the generator (bit r of gen is x^r).
   function automatic int unsigned top_pos_rem(input int n, input int r,
                                               input int unsigned gen);
      int unsigned acc;
      acc = 1;
      for (int i = 1; i < n; i++) begin
         acc = acc << 1;
         if (((acc >> r) & 1) != 0) acc = acc ^ gen;
      end
      return acc;
   endfunction

endpackage

// File: rtl/bch_dec_seq.sv
module bch_dec_seq
   import bch_dec_pkg::*;
#(
   parameter int N = 15
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   sr,
   output phase_e phase,
   output logic   last
);
   localparam int CW = (N > 1) ? $clog2(N) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

   logic [CW-1:0] cnt;

   assign last = (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start && !sr) begin
               phase <= PH_LOAD;
               cnt   <= CW'(1);
            end
            PH_LOAD: if (last) begin
               phase <= PH_HOLD;
               cnt   <= '0;
            end else cnt <= cnt + CW'(1);
            PH_HOLD: if (sr) begin
               phase <= PH_ROT;
               cnt   <= '0;
            end
            PH_ROT: if (last) begin
               phase <= PH_SEND;
               cnt   <= '0;
            end else cnt <= cnt + CW'(1);
            PH_SEND: if (last) begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end else cnt <= cnt + CW'(1);
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R3
   idle_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && sr) |=> (phase == PH_IDLE));

   // R2
   load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOAD && last) |=> (phase == PH_HOLD));

   // R4
   rot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ROT && last) |=> (phase == PH_SEND));

   // R7
   send_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SEND && last) |=> (phase == PH_IDLE));

endmodule

// File: rtl/bch_syn_reg.sv
module bch_syn_reg #(
   parameter int           R    = 4,
   parameter logic [R:0]   GEN  = 5'b10011,
   parameter logic [R-1:0] TRAP = 4'b1001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         first,
   input  logic         shift_in,
   input  logic         bit_in,
   input  logic         rotate,
   output logic         hit,
   output logic [R-1:0] syn
);
   logic [R-1:0] base;
   logic [R-1:0] nxt;
   logic         fb;
   logic         in_bit;

   assign hit    = rotate && (syn == TRAP);
   assign base   = first ? '0 : (syn ^ (hit ? TRAP : '0));
   assign fb     = base[R-1];
   assign in_bit = shift_in & bit_in;

   // One stage per generator coefficient; a tap is built only where g has a 1.
   for (genvar i = 0; i < R; i++) begin : g_stage
      if (i == 0) begin : g_lsb
         assign nxt[0] = fb ^ in_bit;
      end else if (GEN[i]) begin : g_tap
         assign nxt[i] = base[i-1] ^ fb;
      end else begin : g_plain
         assign nxt[i] = base[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 syn <= '0;
      else if (shift_in || rotate) syn <= nxt;
   end

   // R5
   zero_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rotate && syn == '0) |=> (syn == '0));

endmodule

// File: rtl/bch_word_buf.sv
module bch_word_buf #(
   parameter int N = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_in,
   input  logic bit_in,
   input  logic rotate,
   input  logic flip,
   input  logic send,
   output logic top_bit
);
   logic [N-1:0] word;

   assign top_bit = word[N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_in) word <= {word[N-2:0], bit_in};
      else if (rotate)   word <= {word[N-2:0], word[N-1] ^ flip};
      else if (send)     word <= {word[N-2:0], 1'b0};
   end

   // R5
   rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rotate && !flip && !shift_in) |=> ($countones(word) == $countones($past(word))));

endmodule

// File: rtl/bch_meggitt_dec.sv
module bch_meggitt_dec
   import bch_dec_pkg::*;
#(
   parameter int         N   = 15,
   parameter int         R   = 4,
   parameter logic [R:0] GEN = 5'b10011
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sr,
   input  logic d_in,
   output logic d_out,
   output logic d_valid
);
   localparam logic [R-1:0] TRAP = R'(top_pos_rem(N, R, int'(GEN)));

   if (R < 2 || R > 16) begin : g_bad_r
      $error("bch_meggitt_dec: R out of range");
   end
   if (GEN[R] != 1'b1 || GEN[0] != 1'b1) begin : g_bad_gen
      $error("bch_meggitt_dec: generator needs x^R and constant terms");
   end
   if (N <= R || N > (2 ** R) - 1) begin : g_bad_n
      $error("bch_meggitt_dec: N must lie in (R, 2^R-1]");
   end

   phase_e phase;
   logic   last;
   logic   take;
   logic   first;
   logic   rot;
   logic   snd;
   logic   hit;
   logic   top_bit;
   logic [R-1:0] syn;

   bch_dec_seq #(.N(N)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .sr    (sr),
      .phase (phase),
      .last  (last)
   );

   assign first = (phase == PH_IDLE);
   assign take  = (first && start && !sr) || (phase == PH_LOAD);
   assign rot   = (phase == PH_ROT);
   assign snd   = (phase == PH_SEND);

   bch_syn_reg #(.R(R), .GEN(GEN), .TRAP(TRAP)) u_syn (
      .clk      (clk),
      .rst_n    (rst_n),
      .first    (first),
      .shift_in (take),
      .bit_in   (d_in),
      .rotate   (rot),
      .hit      (hit),
      .syn      (syn)
   );

   bch_word_buf #(.N(N)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_in (take),
      .bit_in   (d_in),
      .rotate   (rot),
      .flip     (hit),
      .send     (snd),
      .top_bit  (top_bit)
   );

   assign d_valid = snd;
   assign d_out   = snd & top_bit;

   // Correction count for the current word, checked below.
   logic [1:0] fixes;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       fixes <= '0;
      else if (first)                   fixes <= '0;
      else if (hit && fixes != 2'd3)    fixes <= fixes + 2'd1;
   end

   // R6
   single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fixes <= 2'd1));

   // R6
   syn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rot && last) |=> (syn == '0));

   // R5
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |-> !d_out);

endmodule

// File: tb/tb_bch_meggitt_dec.sv
`timescale 1ns/1ps
module tb_bch_meggitt_dec;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sr = 1'b0;
   logic d_in = 1'b0;
   logic d_out;
   logic d_valid;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    mon_on = 1'b0;
   logic  exp_valid = 1'b0;
   logic  exp_bit = 1'b0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   bch_meggitt_dec dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .sr      (sr),
      .d_in    (d_in),
      .d_out   (d_out),
      .d_valid (d_valid)
   );

   // Codeword with message in x^14..x^4 and remainder mod 1+x+x^4 in x^3..x^0.
   function automatic logic [14:0] enc(input logic [10:0] msg);
      logic [14:0] v;
      v = {msg, 4'b0000};
      for (int i = 14; i >= 4; i--)
         if (v[i]) v = v ^ (15'b000_0000_0001_0011 << (i - 4));
      return {msg, v[3:0]};
   endfunction

   // Per-clock comparison of both outputs against the model's expectation.
   always @(negedge clk) begin
      if (mon_on) begin
         n_chk++;
         if (d_valid !== exp_valid || d_out !== (exp_valid ? exp_bit : 1'b0)) begin
            n_fail++;
            $display("FAIL %s: actual d_valid=%b d_out=%b, expected d_valid=%b d_out=%b at %0t",
                     tag, d_valid, d_out, exp_valid, exp_valid ? exp_bit : 1'b0, $time);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic junk();
      start = 1'($urandom);
      sr    = 1'($urandom);
      d_in  = 1'($urandom);
   endtask

   // Loads rx, waits hold cycles, raises sr and expects exp on the output.
   task automatic frame(input logic [14:0] rx, input logic [14:0] exp,
                        input int hold, input string t);
      tag = t;
      exp_valid = 1'b0;
      tick();
      start = 1'b1; sr = 1'b0; d_in = rx[14];
      for (int i = 13; i >= 0; i--) begin
         tick();
         start = 1'($urandom); sr = 1'($urandom); d_in = rx[i];
      end
      for (int h = 0; h < hold; h++) begin
         tick();
         start = 1'($urandom); sr = 1'b0; d_in = 1'($urandom);
      end
      tick();
      sr = 1'b1; start = 1'($urandom); d_in = 1'($urandom);
      // edges E .. E+14: rotation, no output
      for (int j = 0; j < 15; j++) begin
         tick();
         junk();
      end
      // edges E+15 .. E+29: output window (R4)
      for (int k = 0; k < 15; k++) begin
         if (k == 0) begin
            // first tick already taken by loop above ending on E+14; advance
         end
         tick();
         exp_valid = 1'b1;
         exp_bit   = exp[14-k];
         if (k < 14) junk();
         else begin start = 1'b0; sr = 1'b0; d_in = 1'b0; end
      end
      tick();
      exp_valid = 1'b0;
      start = 1'b0; sr = 1'b0; d_in = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual run still busy after 150000 cycles, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [14:0] cw;
      // R1: outputs quiet during reset
      repeat (3) begin
         @(negedge clk);
         n_chk++;
         if (d_valid !== 1'b0 || d_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual d_valid=%b d_out=%b, expected 0 0", d_valid, d_out);
         end
      end
      tick();
      rst_n = 1'b1;
      tag = "R1";
      mon_on = 1'b1;
      tick();

      // R6: worked example
      frame(15'b111110001100111, 15'b110110001100111, 0, "R6 example");
      // R5: clean codewords
      frame(15'h0000, 15'h0000, 1, "R5 all-zero");
      frame(15'h7FFF, 15'h7FFF, 2, "R5 all-one");
      for (int n = 0; n < 5; n++) begin
         cw = enc(11'($urandom));
         frame(cw, cw, n, "R5 clean");
      end
      // R2: ordering, distinct pattern with a lone high-order one
      cw = enc(11'b100_0000_0000);
      frame(cw, cw, 0, "R2 order");
      // R4: long wait before sr
      cw = enc(11'($urandom));
      frame(cw ^ 15'h0001, cw, 40, "R4 long hold");
      // R3: start together with sr in idle is ignored
      tag = "R3";
      for (int c = 0; c < 5; c++) begin
         tick();
         start = 1'b1; sr = 1'b1; d_in = 1'($urandom);
      end
      tick();
      start = 1'b0; sr = 1'b0;
      cw = enc(11'($urandom));
      frame(cw, cw, 0, "R3 after ignored start");
      // R6 / R7: every single-bit error position, frames back to back
      for (int p = 0; p < 15; p++) begin
         for (int rep = 0; rep < 4; rep++) begin
            cw = enc(11'($urandom));
            frame(cw ^ (15'h0001 << p), cw, rep, (rep == 0) ? "R7 back-to-back" : "R6 single error");
         end
      end
      tick();
      tick();
      mon_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule